// File: doc/BRIEF.md
# Multi-Match Timer with Snapshot Read

This peripheral holds a set of independent up-counters on a simple word-addressed register bus. Each counter has several match comparators, a preload value and a reload-select mask. A counter advances by one on each cycle where the shared `tick` input is high and that counter's run bit is set. When the counter equals a comparator that the reload mask selects, the next tick loads the preload value instead of incrementing.

Each comparator has a sticky status bit, a write-one-to-clear bit and an interrupt-enable bit. Each counter drives one interrupt line.

Software does not read a live counter directly. It writes a capture request and, a fixed few cycles later, the counter value is latched into a snapshot register. A read of that same address returns the snapshot. A read made before the capture lands still sees the older snapshot.

Top module: `mmt_timer`

## Requirements
- R1: After reset every counter and every snapshot is 0, every status, interrupt-enable and reload-select field is 0, the run mask is 0, `irq` is 0, and every match register reads all ones.
- R2: Word offsets with the default sizes are as follows. Match register for timer t, comparator c sits at 3·t+c (0–8). Preload t is at 9+t. Reload select t is at 12+t. Status t is at 15+t. Interrupt enable t is at 18+t. Clear t is at 21+t. The run mask is at 24. Capture t is at 25+t. Values written to writable registers read back, zero-extended to the bus width.
- R3: A counter changes only at a clock edge where `tick` is 1 and bit t of the run mask is 1. Bit 0 belongs to timer 0. Otherwise it holds its value.
- R4: On a counted tick with no selected match, the counter increments by one and wraps from all ones to 0.
- R5: Bit c of a timer's reload-select field picks comparator c, so the value 1 picks comparator 0. If the counter equals any selected comparator on a counted tick, the counter loads the preload value. A field of 0 never reloads.
- R6: On a counted tick where the counter equals match register c, status bit c of that timer becomes 1 at that edge. It stays 1 until it is cleared.
- R7: Writing the clear register of timer t clears exactly the status bits written as 1. Writes to a status address have no effect.
- R8: `irq[t]` is 1 exactly when some status bit of timer t is 1 and its interrupt-enable bit is also 1.
- R9: A write to capture t with bit 0 set latches that counter's value into the snapshot 3 clock edges after the write edge. The latched value is the one the counter holds just before that third edge. A read of capture t returns the snapshot.
- R10: A capture read issued before the capture lands returns the previous snapshot. A capture write with bit 0 clear requests nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle count strobe from the divided function clock |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when not reading |
| irq | output | NUM_TMR | Per-timer interrupt line |

## Verification
The properties take for granted the following about the inputs:
- `tick` may take any pattern.
- Bus offsets stay inside the map.
- The counter width is no wider than the bus.

The reload and increment properties compare the counter's next value against the preload and match registers as they stood at the counted edge. Because of that, the stimulus never rewrites a preload or match register on the same edge as a counted tick.

The stimulus also has these habits:
- It stops the run mask before clearing status. A clear then never collides with a new hit.
- It drives every bus access and tick change on the falling edge.
- It keeps the counter at 8 bits, so wraps and whole reload periods are reached in a few hundred ticks.

// File: rtl/mmt_pkg.sv
`timescale 1ns/1ps
package mmt_pkg;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_MATCH,
        REG_PRELOAD,
        REG_RSEL,
        REG_STATUS,
        REG_IEN,
        REG_ICLR,
        REG_RUN,
        REG_SNAP
    } mmt_reg_e;

    typedef struct packed {
        mmt_reg_e   kind;
        logic [7:0] idx;
    } mmt_dec_t;

    // Total number of word offsets used by the map.
    function automatic int mmt_span(input int nt, input int nc);
        return nt * nc + 6 * nt + 1;
    endfunction

    // Map a word offset to a register class and an index inside the class.
    function automatic mmt_dec_t mmt_decode(input logic [7:0] addr, input int nt, input int nc);
        mmt_dec_t d;
        int w;
        int b;
        w      = int'(addr);
        b      = nt * nc;
        d.kind = REG_NONE;
        d.idx  = '0;
        if (w < b) begin
            d.kind = REG_MATCH;   d.idx = 8'(w);
        end else if (w < b + nt) begin
            d.kind = REG_PRELOAD; d.idx = 8'(w - b);
        end else if (w < b + 2 * nt) begin
            d.kind = REG_RSEL;    d.idx = 8'(w - b - nt);
        end else if (w < b + 3 * nt) begin
            d.kind = REG_STATUS;  d.idx = 8'(w - b - 2 * nt);
        end else if (w < b + 4 * nt) begin
            d.kind = REG_IEN;     d.idx = 8'(w - b - 3 * nt);
        end else if (w < b + 5 * nt) begin
            d.kind = REG_ICLR;    d.idx = 8'(w - b - 4 * nt);
        end else if (w == b + 5 * nt) begin
            d.kind = REG_RUN;     d.idx = '0;
        end else if (w < mmt_span(nt, nc)) begin
            d.kind = REG_SNAP;    d.idx = 8'(w - b - 5 * nt - 1);
        end
        return d;
    endfunction

endpackage

// File: rtl/mmt_channel.sv
`timescale 1ns/1ps
module mmt_channel #(
    parameter int NUM_CMP = 3,
    parameter int CNT_W   = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            tick,
    input  logic                            run,
    input  logic [NUM_CMP-1:0][CNT_W-1:0]   match,
    input  logic [CNT_W-1:0]                preload,
    input  logic [NUM_CMP-1:0]              rsel,
    input  logic [NUM_CMP-1:0]              ien,
    input  logic [NUM_CMP-1:0]              clr,
    output logic [CNT_W-1:0]                count,
    output logic [NUM_CMP-1:0]              status,
    output logic                            irq
);

    logic               step;
    logic               reload;
    logic [NUM_CMP-1:0] hit;

    assign step = tick & run;

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        assign hit[c] = step && (count == match[c]);
    end

    assign reload = |(hit & rsel);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (step) begin
            count <= reload ? preload : count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= (status & ~clr) | hit;
        end
    end

    assign irq = |(status & ien);

endmodule

// File: rtl/mmt_snap.sv
`timescale 1ns/1ps
module mmt_snap #(
    parameter int CNT_W = 32,
    parameter int LAT   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] snap
);

    logic [LAT-1:0] pipe;

    if (LAT == 1) begin : g_one
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= req;
        end
    end else begin : g_many
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[LAT-2:0], req};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (pipe[LAT-1]) begin
            snap <= live;
        end
    end

endmodule

// File: rtl/mmt_timer.sv
`timescale 1ns/1ps
module mmt_timer
    import mmt_pkg::*;
#(
    parameter int NUM_TMR = 3,
    parameter int NUM_CMP = 3,
    parameter int CNT_W   = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 6,
    parameter int CAP_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_TMR-1:0] irq
);

    localparam int SPAN = mmt_span(NUM_TMR, NUM_CMP);

    mmt_dec_t dec;
    logic     wr_en;
    logic     rd_en;

    logic [NUM_TMR-1:0][NUM_CMP-1:0][CNT_W-1:0] match_q;
    logic [NUM_TMR-1:0][CNT_W-1:0]              pre_q;
    logic [NUM_TMR-1:0][CNT_W-1:0]              cnt_w;
    logic [NUM_TMR-1:0][CNT_W-1:0]              snap_w;
    logic [NUM_TMR-1:0][NUM_CMP-1:0]            rsel_q;
    logic [NUM_TMR-1:0][NUM_CMP-1:0]            ien_q;
    logic [NUM_TMR-1:0][NUM_CMP-1:0]            stat_w;
    logic [NUM_TMR-1:0][NUM_CMP-1:0]            clr_p;
    logic [NUM_TMR-1:0]                         en_q;
    logic [NUM_TMR-1:0]                         cap_req;

    assign dec   = mmt_decode(8'(bus_addr), NUM_TMR, NUM_CMP);
    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_en && dec.kind == REG_RUN) begin
            en_q <= bus_wdata[NUM_TMR-1:0];
        end
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        logic [NUM_CMP-1:0][CNT_W-1:0] m_q;
        logic [CNT_W-1:0]              p_q;
        logic [NUM_CMP-1:0]            r_q;
        logic [NUM_CMP-1:0]            e_q;
        logic                          sel_t;

        assign sel_t = (dec.idx == 8'(t));

        always_ff @(posedge clk) begin
            if (rst) begin
                m_q <= '1;
                p_q <= '0;
                r_q <= '0;
                e_q <= '0;
            end else if (wr_en) begin
                for (int c = 0; c < NUM_CMP; c++) begin
                    if (dec.kind == REG_MATCH && dec.idx == 8'(t * NUM_CMP + c)) begin
                        m_q[c] <= bus_wdata[CNT_W-1:0];
                    end
                end
                if (sel_t && dec.kind == REG_PRELOAD) p_q <= bus_wdata[CNT_W-1:0];
                if (sel_t && dec.kind == REG_RSEL)    r_q <= bus_wdata[NUM_CMP-1:0];
                if (sel_t && dec.kind == REG_IEN)     e_q <= bus_wdata[NUM_CMP-1:0];
            end
        end

        assign match_q[t] = m_q;
        assign pre_q[t]   = p_q;
        assign rsel_q[t]  = r_q;
        assign ien_q[t]   = e_q;

        assign clr_p[t]   = (wr_en && sel_t && dec.kind == REG_ICLR) ? bus_wdata[NUM_CMP-1:0] : '0;
        assign cap_req[t] = wr_en && sel_t && dec.kind == REG_SNAP && bus_wdata[0];

        mmt_channel #(
            .NUM_CMP (NUM_CMP),
            .CNT_W   (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .run     (en_q[t]),
            .match   (m_q),
            .preload (p_q),
            .rsel    (r_q),
            .ien     (e_q),
            .clr     (clr_p[t]),
            .count   (cnt_w[t]),
            .status  (stat_w[t]),
            .irq     (irq[t])
        );

        mmt_snap #(
            .CNT_W (CNT_W),
            .LAT   (CAP_LAT)
        ) u_snap (
            .clk  (clk),
            .rst  (rst),
            .req  (cap_req[t]),
            .live (cnt_w[t]),
            .snap (snap_w[t])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en && int'(bus_addr) < SPAN) begin
            for (int t = 0; t < NUM_TMR; t++) begin
                for (int c = 0; c < NUM_CMP; c++) begin
                    if (dec.kind == REG_MATCH && dec.idx == 8'(t * NUM_CMP + c)) begin
                        bus_rdata = DATA_W'(match_q[t][c]);
                    end
                end
                if (dec.idx == 8'(t)) begin
                    case (dec.kind)
                        REG_PRELOAD: bus_rdata = DATA_W'(pre_q[t]);
                        REG_RSEL:    bus_rdata = DATA_W'(rsel_q[t]);
                        REG_STATUS:  bus_rdata = DATA_W'(stat_w[t]);
                        REG_IEN:     bus_rdata = DATA_W'(ien_q[t]);
                        REG_SNAP:    bus_rdata = DATA_W'(snap_w[t]);
                        default:     ;
                    endcase
                end
            end
            if (dec.kind == REG_RUN) bus_rdata = DATA_W'(en_q);
        end
    end

endmodule

// File: rtl/mmt_timer_chk.sv
`timescale 1ns/1ps
module mmt_timer_chk #(
    parameter int NT = 3,
    parameter int NC = 3,
    parameter int CW = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        tick,
    input logic [NT-1:0]               run,
    input logic [NT-1:0][CW-1:0]       count,
    input logic [NT-1:0][CW-1:0]       preload,
    input logic [NT-1:0][NC-1:0][CW-1:0] match,
    input logic [NT-1:0][NC-1:0]       rsel,
    input logic [NT-1:0][NC-1:0]       status,
    input logic [NT-1:0][NC-1:0]       clr
);

    for (genvar t = 0; t < NT; t++) begin : g_t
        logic sel_hit;

        always_comb begin
            sel_hit = 1'b0;
            for (int c = 0; c < NC; c++) begin
                if (rsel[t][c] && count[t] == match[t][c]) sel_hit = 1'b1;
            end
        end

        // R3: idle counters hold
        a_r3_hold: assert property (@(posedge clk) disable iff (rst)
            !(tick && run[t]) |=> count[t] == $past(count[t]));

        // R4: counted tick without a selected match steps by one
        a_r4_step: assert property (@(posedge clk) disable iff (rst)
            (tick && run[t] && !sel_hit) |=> count[t] == CW'($past(count[t]) + 1'b1));

        // R5: selected match reloads the preload value
        a_r5_reload: assert property (@(posedge clk) disable iff (rst)
            (tick && run[t] && sel_hit) |=> count[t] == $past(preload[t]));

        for (genvar c = 0; c < NC; c++) begin : g_c
            // R6: a status bit rises only after a counted tick at a match
            a_r6_cause: assert property (@(posedge clk) disable iff (rst)
                $rose(status[t][c]) |-> $past(tick && run[t] && count[t] == match[t][c]));

            // R7: a status bit stays set unless it is cleared
            a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
                (status[t][c] && !clr[t][c]) |=> status[t][c]);
        end
    end

endmodule

bind mmt_timer mmt_timer_chk #(
    .NT (NUM_TMR),
    .NC (NUM_CMP),
    .CW (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .run     (en_q),
    .count   (cnt_w),
    .preload (pre_q),
    .match   (match_q),
    .rsel    (rsel_q),
    .status  (stat_w),
    .clr     (clr_p)
);

// File: tb/mmt_timer_bench.sv
`timescale 1ns/1ps
module mmt_timer_bench;

    localparam int NT = 3;
    localparam int NC = 3;
    localparam int CW = 8;
    localparam int O_MATCH = 0;
    localparam int O_PRE   = 9;
    localparam int O_RSEL  = 12;
    localparam int O_STAT  = 15;
    localparam int O_IEN   = 18;
    localparam int O_CLR   = 21;
    localparam int O_RUN   = 24;
    localparam int O_SNAP  = 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NT-1:0] irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mmt_timer #(
        .NUM_TMR (NT),
        .NUM_CMP (NC),
        .CNT_W   (CW),
        .DATA_W  (32),
        .ADDR_W  (6),
        .CAP_LAT (3)
    ) u_mmt_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick = 1'b0; sel = 1'b0; wr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bw(input int a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 6'(a); wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic br(input int a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = 6'(a);
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic snap_read(input int t, output logic [31:0] d);
        bw(O_SNAP + t, 32'h1);
        repeat (3) @(negedge clk);
        br(O_SNAP + t, d);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int m;
        int exp;

        // R1 reset state
        do_reset();
        br(O_MATCH + 4, v);  check("R1 match reset", v, 32'hFF);
        br(O_PRE + 1, v);    check("R1 preload reset", v, 0);
        br(O_RSEL + 2, v);   check("R1 rsel reset", v, 0);
        br(O_IEN, v);        check("R1 ien reset", v, 0);
        br(O_RUN, v);        check("R1 run reset", v, 0);
        br(O_STAT + 1, v);   check("R1 status reset", v, 0);
        br(O_SNAP, v);       check("R1 snap reset", v, 0);
        check("R1 irq reset", 32'(irq), 0);

        // R2 map and readback
        for (int i = 0; i < NT * NC; i++) bw(O_MATCH + i, 32'(8'h30 + i));
        for (int i = 0; i < NT * NC; i++) begin
            br(O_MATCH + i, v);
            check("R2 match index", v, 32'(8'h30 + i));
        end
        bw(O_PRE + 1, 32'hFFFF_FFA5); br(O_PRE + 1, v); check("R2 preload readback", v, 32'hA5);
        bw(O_RSEL + 2, 32'h5);        br(O_RSEL + 2, v); check("R2 rsel readback", v, 32'h5);
        bw(O_IEN + 1, 32'h6);         br(O_IEN + 1, v);  check("R2 ien readback", v, 32'h6);

        // R3 run gating
        do_reset();
        ticks(10);
        snap_read(0, v); check("R3 no run no count", v, 0);
        bw(O_RUN, 32'h1);
        ticks(5);
        snap_read(0, v); check("R3 timer0 counts", v, 5);
        snap_read(1, v); check("R3 timer1 held", v, 0);
        snap_read(2, v); check("R3 timer2 held", v, 0);
        repeat (10) @(negedge clk);
        snap_read(0, v); check("R3 no tick no count", v, 5);

        // R4 wrap, R6 status, R7 clear, R8 irq
        do_reset();
        bw(O_MATCH + 0, 32'hFF); bw(O_MATCH + 1, 32'h10); bw(O_MATCH + 2, 32'h80);
        bw(O_RSEL + 0, 32'h1);
        bw(O_RUN, 32'h3);
        ticks(300);
        snap_read(0, v); check("R4 wrap with reload to 0", v, 300 % 256);
        snap_read(1, v); check("R4 wrap free running", v, 300 % 256);
        br(O_STAT + 0, v); check("R6 status all hits t0", v, 7);
        br(O_STAT + 1, v); check("R6 status all hits t1", v, 7);
        check("R8 irq with no enables", 32'(irq), 0);
        bw(O_RUN, 32'h0);
        bw(O_CLR + 0, 32'h2);
        br(O_STAT + 0, v); check("R7 clear one bit", v, 5);
        bw(O_STAT + 0, 32'h0);
        br(O_STAT + 0, v); check("R7 status write ignored", v, 5);
        bw(O_IEN + 1, 32'h4);
        check("R8 irq t1 only", 32'(irq), 32'h2);
        bw(O_IEN + 0, 32'h2);
        check("R8 enabled bit already cleared", 32'(irq), 32'h2);

        // R5/R6/R7/R8 sweep of every timer and comparator
        for (int t = 0; t < NT; t++) begin
            for (int c = 0; c < NC; c++) begin
                do_reset();
                m = 10 + 4 * c + t;
                bw(O_MATCH + NC * t + c, 32'(m));
                bw(O_PRE + t, 32'd3);
                bw(O_RSEL + t, 32'(1 << c));
                bw(O_RUN, 32'(1 << t));
                ticks(37);
                exp = (37 <= m) ? 37 : 3 + ((37 - m - 1) % (m - 3 + 1));
                snap_read(t, v); check("R5 reload period", v, 32'(exp));
                br(O_STAT + t, v); check("R6 status bit of comparator", v, 32'(1 << c));
                check("R8 irq masked", 32'(irq), 0);
                bw(O_IEN + t, 32'(1 << c));
                check("R8 irq raised", 32'(irq), 32'(1 << t));
                bw(O_RUN, 32'h0);
                bw(O_CLR + t, 32'(1 << c));
                br(O_STAT + t, v); check("R7 cleared", v, 0);
                check("R8 irq dropped", 32'(irq), 0);
            end
        end

        // R5 two selected comparators, first reached wins
        do_reset();
        bw(O_MATCH + 6, 32'd20); bw(O_MATCH + 7, 32'd12);
        bw(O_PRE + 2, 32'd5);
        bw(O_RSEL + 2, 32'h3);
        bw(O_RUN, 32'h4);
        ticks(30);
        snap_read(2, v); check("R5 multiple selects", v, 6);

        // R9/R10 capture latency
        do_reset();
        bw(O_RUN, 32'h1);
        @(negedge clk);
        tick = 1'b1; sel = 1'b1; wr = 1'b1; addr = 6'(O_SNAP); wdata = 32'h1;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        @(negedge clk);
        sel = 1'b1; addr = 6'(O_SNAP);
        #1 check("R10 early read old snapshot", rdata, 0);
        sel = 1'b0;
        @(negedge clk);
        @(negedge clk);
        tick = 1'b0;
        br(O_SNAP, v); check("R9 capture after three edges", v, 3);
        snap_read(0, v); check("R9 capture idle counter", v, 4);
        ticks(5);
        bw(O_SNAP, 32'h0);
        repeat (4) @(negedge clk);
        br(O_SNAP, v); check("R10 bit0 clear no request", v, 4);
        snap_read(0, v); check("R9 capture refreshed", v, 9);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule